// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block works out the column address for each beat of a DDR SDRAM read or write burst. A mode-register load sets the burst length (2, 4 or 8 beats) and the ordering (sequential wrap or interleaved). The ordering covers only the low column bits inside one aligned block. When a burst starts, the block takes a bank number and a column. It stores the aligned base column and the starting offset in that bank's own slot, together with the length and ordering in force at that moment.

Each later beat-advance strobe for that bank moves its beat counter on by one. One cycle after each start or advance, the block shows the column for that beat and a flag that marks the final beat. Four banks keep separate state, so a controller can interleave bursts to different banks without losing where each one stands. If the mode register is changed while a burst is running, that burst is not affected.

Top module: `ddr_burst_colseq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block resets. Afterwards `beat_valid` is 0, `mode_err` is 0, `beat_col` is 0, every bank is idle, and the mode is burst length 2 with sequential ordering.
- R2: When `mrs_valid` is high, `mrs_value[2:0]` sets the burst length: 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8. `mrs_value[3]` sets the ordering: 0 is sequential, 1 is interleaved. The new setting applies to starts from the next cycle onward.
- R3: A load whose `mrs_value[2:0]` is any other code leaves both the length and the ordering unchanged and sets `mode_err` from the next cycle. The next valid load clears `mode_err`.
- R4: In the cycle after `start_valid`, `beat_valid` is 1, `beat_col` equals `start_col`, and `beat_last` is 0.
- R5: Sequential ordering: beat n of a burst with length BL and start column c gives (c with its low log2(BL) bits cleared) OR ((c mod BL + n) mod BL).
- R6: Interleaved ordering: beat n gives (c with its low log2(BL) bits cleared) OR ((c mod BL) XOR n).
- R7: `beat_last` is 1 exactly on beat BL-1 of a burst and 0 on every earlier beat.
- R8: An advance to a bank that has no burst in progress has no effect. This covers a bank whose last beat has already been shown and a bank that has not been started since reset. In the cycle after such an advance `beat_valid` is 0, and the bank's next beat is unchanged.
- R9: Each bank keeps its own base, offset, beat count, length and ordering. Advancing or starting one bank does not disturb any other bank, and a mode load in the middle of a burst does not change that burst.
- R10: When `start_valid` and `adv_valid` are both high in a cycle, the start is carried out and the advance is dropped, whichever bank the advance names. If both name the same bank, the burst restarts at beat 0.
- R11: Outputs follow an event by exactly one cycle. In a cycle after neither a start nor an effective advance, `beat_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mrs_valid | input | 1 | Load the mode register this cycle |
| mrs_value | input | MODE_W (13) | Mode register value; [2:0] length code, [3] ordering |
| start_valid | input | 1 | Start a burst this cycle |
| start_bank | input | BANK_W (2) | Bank of the burst being started |
| start_col | input | COL_W (10) | Column given with the start |
| adv_valid | input | 1 | Advance a bank to its next beat |
| adv_bank | input | BANK_W (2) | Bank being advanced |
| beat_valid | output | 1 | Beat address is new this cycle |
| beat_col | output | COL_W (10) | Column address of the reported beat |
| beat_last | output | 1 | Reported beat is the final beat of its burst |
| mode_err | output | 1 | Last mode load carried a reserved length code |

## Verification
The bench builds the block with its default parameters: ten column bits and four banks. With these values it can set the column bits above the burst block to a non-zero pattern and show that every beat keeps them. It also runs every combination of bank, starting offset, burst length and ordering, which covers each row of the interleave table and each wrap point. Directed sequences cover interleaving bursts across banks, a mode change during a burst, advances that should be ignored, a start and an advance in the same cycle, and reserved length codes.

// File: rtl/ddr_colseq_pkg.sv
// Package: shared widths and helpers for the burst column sequencer.
// Assumes burst lengths of 2, 4 or 8, held as log2 values 1..3.
package ddr_colseq_pkg;

    localparam int OFF_W = 3;

    typedef logic [1:0]       lg_t;
    typedef logic [OFF_W-1:0] off_t;

    // Low-bit mask of the burst block for a log2 burst length.
    function automatic off_t lg_mask(input lg_t lg);
        case (lg)
            2'd1:    return 3'b001;
            2'd2:    return 3'b011;
            2'd3:    return 3'b111;
            default: return 3'b001;
        endcase
    endfunction

    // True when a three-bit length code is one of the legal ones.
    function automatic logic code_ok(input logic [2:0] code);
        return (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
    endfunction

endpackage

// File: rtl/ddr_colseq_mode.sv
// Module: mode register decode.
// Holds the burst length (as log2) and the ordering. A load with a reserved
// length code is rejected as a whole and raises the error flag. The next
// legal load clears the flag. Bits above the ordering bit are not used.
module ddr_colseq_mode
    import ddr_colseq_pkg::*;
#(
    parameter int MODE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_valid,
    input  logic [MODE_W-1:0] mrs_value,
    output lg_t               mode_lg,
    output logic              mode_itl,
    output logic              mode_err
);

    logic mode_unused;
    assign mode_unused = ^mrs_value[MODE_W-1:4];

    // Mode state update: take legal loads, flag reserved codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_lg  <= 2'd1;
            mode_itl <= 1'b0;
            mode_err <= 1'b0;
        end else if (mrs_valid) begin
            if (code_ok(mrs_value[2:0])) begin
                mode_lg  <= mrs_value[1:0];
                mode_itl <= mrs_value[3];
                mode_err <= 1'b0;
            end else begin
                mode_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ddr_colseq_bank.sv
// Module: burst state for one bank.
// On a start it stores the aligned base, the start offset and the mode in
// force at that moment, and clears the beat count. Each accepted advance
// moves the count on by one. The offset is worked out from the start
// offset and the count. The bank is busy until its last beat has been shown.
module ddr_colseq_bank
    import ddr_colseq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_hit,
    input  logic             adv_hit,
    input  logic [COL_W-1:0] start_col,
    input  lg_t              mode_lg,
    input  logic             mode_itl,
    output logic [COL_W-1:0] col,
    output logic             last,
    output logic             busy
);

    localparam int HI_W = COL_W - OFF_W;

    logic [COL_W-1:0] base_q;
    off_t             soff_q;
    off_t             cnt_q;
    lg_t              lg_q;
    logic             itl_q;
    logic             busy_q;

    off_t             smask;
    off_t             cmask;
    off_t             off;
    logic [COL_W-1:0] smask_w;

    assign smask   = lg_mask(mode_lg);
    assign smask_w = {{HI_W{1'b0}}, smask};
    assign cmask   = lg_mask(lg_q);

    // Per-bank burst state: start loads, an advance counts on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            soff_q <= '0;
            cnt_q  <= '0;
            lg_q   <= 2'd1;
            itl_q  <= 1'b0;
            busy_q <= 1'b0;
        end else if (start_hit) begin
            base_q <= start_col & ~smask_w;
            soff_q <= start_col[OFF_W-1:0] & smask;
            cnt_q  <= '0;
            lg_q   <= mode_lg;
            itl_q  <= mode_itl;
            busy_q <= 1'b1;
        end else if (adv_hit && busy_q) begin
            cnt_q  <= cnt_q + 3'd1;
            busy_q <= ((cnt_q + 3'd1) != cmask);
        end
    end

    // Offset of the current beat for the ordering stored with the burst.
    always_comb begin
        if (itl_q) off = soff_q ^ cnt_q;
        else       off = (soff_q + cnt_q) & cmask;
    end

    assign col  = base_q | {{HI_W{1'b0}}, off};
    assign last = (cnt_q == cmask);
    assign busy = busy_q;

endmodule

// File: rtl/ddr_colseq_out.sv
// Module: output stage.
// Records which bank the last event hit and whether the event took effect.
// It then shows that bank's current beat, one cycle after the event.
module ddr_colseq_out #(
    parameter int COL_W  = 10,
    parameter int NB     = 4,
    parameter int BANK_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic [BANK_W-1:0] evt_bank,
    input  logic [COL_W-1:0] col_arr [NB],
    input  logic             last_arr [NB],
    output logic             beat_valid,
    output logic [COL_W-1:0] beat_col,
    output logic             beat_last
);

    logic              valid_q;
    logic [BANK_W-1:0] sel_q;

    // Event capture: remember the bank that was touched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            sel_q   <= '0;
        end else begin
            valid_q <= evt;
            if (evt) sel_q <= evt_bank;
        end
    end

    assign beat_valid = valid_q;
    assign beat_col   = col_arr[sel_q];
    assign beat_last  = valid_q & last_arr[sel_q];

endmodule

// File: rtl/ddr_burst_colseq.sv
// Module: DDR burst column address sequencer (top).
// Decodes the mode register, keeps one burst slot per bank, and shows the
// beat address of the bank touched by the last start or accepted advance.
// A start takes priority over any advance in the same cycle.
// Assumes COL_W > 3 and NB a power of two.
module ddr_burst_colseq
    import ddr_colseq_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int MODE_W = 13,
    parameter int NB     = 4,
    parameter int BANK_W = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_valid,
    input  logic [MODE_W-1:0] mrs_value,
    input  logic              start_valid,
    input  logic [BANK_W-1:0] start_bank,
    input  logic [COL_W-1:0]  start_col,
    input  logic              adv_valid,
    input  logic [BANK_W-1:0] adv_bank,
    output logic              beat_valid,
    output logic [COL_W-1:0]  beat_col,
    output logic              beat_last,
    output logic              mode_err
);

    lg_t               mode_lg;
    logic              mode_itl;
    logic [COL_W-1:0]  col_arr  [NB];
    logic              last_arr [NB];
    logic              busy_arr [NB];
    logic              evt;
    logic [BANK_W-1:0] evt_bank;

    ddr_colseq_mode #(.MODE_W(MODE_W)) mode_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mrs_valid (mrs_valid),
        .mrs_value (mrs_value),
        .mode_lg   (mode_lg),
        .mode_itl  (mode_itl),
        .mode_err  (mode_err)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic s_hit;
        logic a_hit;
        assign s_hit = start_valid && (start_bank == BANK_W'(b));
        assign a_hit = adv_valid && !start_valid && (adv_bank == BANK_W'(b));

        ddr_colseq_bank #(.COL_W(COL_W)) bank_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_hit (s_hit),
            .adv_hit   (a_hit),
            .start_col (start_col),
            .mode_lg   (mode_lg),
            .mode_itl  (mode_itl),
            .col       (col_arr[b]),
            .last      (last_arr[b]),
            .busy      (busy_arr[b])
        );
    end

    // Event select: a start wins; an advance counts only on a busy bank.
    always_comb begin
        if (start_valid) begin
            evt      = 1'b1;
            evt_bank = start_bank;
        end else begin
            evt      = adv_valid && busy_arr[adv_bank];
            evt_bank = adv_bank;
        end
    end

    ddr_colseq_out #(.COL_W(COL_W), .NB(NB), .BANK_W(BANK_W)) out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .evt_bank   (evt_bank),
        .col_arr    (col_arr),
        .last_arr   (last_arr),
        .beat_valid (beat_valid),
        .beat_col   (beat_col),
        .beat_last  (beat_last)
    );

endmodule

// File: rtl/ddr_colseq_chk.sv
// Checker: port-level properties of the burst column sequencer.
module ddr_colseq_chk #(
    parameter int COL_W  = 10,
    parameter int MODE_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mrs_valid,
    input logic [MODE_W-1:0] mrs_value,
    input logic              start_valid,
    input logic [COL_W-1:0]  start_col,
    input logic              adv_valid,
    input logic              beat_valid,
    input logic [COL_W-1:0]  beat_col,
    input logic              beat_last,
    input logic              mode_err
);

    a_r4_start_col: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |=> (beat_valid && beat_col == $past(start_col)));

    a_r7_first_not_last: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |=> !beat_last);

    a_r3_bad_code_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_valid && !(mrs_value[2:0] inside {3'd1, 3'd2, 3'd3})) |=> mode_err);

    a_r3_good_code_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_valid && (mrs_value[2:0] inside {3'd1, 3'd2, 3'd3})) |=> !mode_err);

    a_r11_idle_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_valid && !adv_valid) |=> !beat_valid);

    a_r7_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

endmodule

bind ddr_burst_colseq ddr_colseq_chk #(.COL_W(COL_W), .MODE_W(MODE_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mrs_valid   (mrs_valid),
    .mrs_value   (mrs_value),
    .start_valid (start_valid),
    .start_col   (start_col),
    .adv_valid   (adv_valid),
    .beat_valid  (beat_valid),
    .beat_col    (beat_col),
    .beat_last   (beat_last),
    .mode_err    (mode_err)
);

// File: tb/ddr_burst_colseq_tb_top.sv
`timescale 1ns/1ps
module ddr_burst_colseq_tb_top;

    localparam int COL_W  = 10;
    localparam int MODE_W = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mrs_valid = 1'b0;
    logic [MODE_W-1:0] mrs_value = '0;
    logic              start_valid = 1'b0;
    logic [1:0]        start_bank = '0;
    logic [COL_W-1:0]  start_col = '0;
    logic              adv_valid = 1'b0;
    logic [1:0]        adv_bank = '0;
    logic              beat_valid;
    logic [COL_W-1:0]  beat_col;
    logic              beat_last;
    logic              mode_err;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    ddr_burst_colseq #(.COL_W(COL_W), .MODE_W(MODE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mrs_valid(mrs_valid), .mrs_value(mrs_value),
        .start_valid(start_valid), .start_bank(start_bank), .start_col(start_col),
        .adv_valid(adv_valid), .adv_bank(adv_bank), .beat_valid(beat_valid),
        .beat_col(beat_col), .beat_last(beat_last), .mode_err(mode_err)
    );

    // Vectors: {interleave, log2 length, bank, column}
    localparam logic [14:0] VEC [12] = '{
        {1'b0, 2'd1, 2'd0, 10'h3ff}, {1'b1, 2'd1, 2'd1, 10'h2a4},
        {1'b0, 2'd2, 2'd2, 10'h156}, {1'b1, 2'd2, 2'd3, 10'h0c1},
        {1'b0, 2'd3, 2'd0, 10'h2fd}, {1'b1, 2'd3, 2'd1, 10'h1e5},
        {1'b0, 2'd3, 2'd2, 10'h007}, {1'b1, 2'd3, 2'd3, 10'h3fa},
        {1'b0, 2'd2, 2'd1, 10'h203}, {1'b1, 2'd2, 2'd0, 10'h11e},
        {1'b1, 2'd1, 2'd2, 10'h000}, {1'b0, 2'd1, 2'd3, 10'h0f1}
    };

    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] c,
            input int lg, input logic itl, input int n);
        int msk = (1 << lg) - 1;
        int s   = int'(c) & msk;
        int off = itl ? ((s ^ n) & msk) : ((s + n) & msk);
        return COL_W'((int'(c) & ~msk) | off);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        mrs_valid   = 1'b0;
        start_valid = 1'b0;
        adv_valid   = 1'b0;
    endtask

    task automatic do_mrs(input logic [2:0] code, input logic itl);
        mrs_valid = 1'b1;
        mrs_value = {9'd0, itl, code};
        tick();
    endtask

    task automatic do_start(input int b, input logic [COL_W-1:0] c);
        start_valid = 1'b1;
        start_bank  = 2'(b);
        start_col   = c;
        tick();
    endtask

    task automatic do_adv(input int b);
        adv_valid = 1'b1;
        adv_bank  = 2'(b);
        tick();
    endtask

    // Full burst against the model, then one ignored advance.
    task automatic run_burst(input int b, input logic [COL_W-1:0] c,
            input int lg, input logic itl, input bit quiet_ok);
        int bl = 1 << lg;
        do_mrs(3'(lg), itl);
        do_start(b, c);
        chk("R4 start valid", int'(beat_valid), 1);
        chk("R4 start col", int'(beat_col), int'(c));
        for (int n = 1; n < bl; n++) begin
            do_adv(b);
            chk(itl ? "R6 interleaved col" : "R5 sequential col",
                int'(beat_col), int'(exp_col(c, lg, itl, n)));
            chk("R7 last flag", int'(beat_last), (n == bl - 1) ? 1 : 0);
            if (!quiet_ok) chk("R11 beat valid", int'(beat_valid), 1);
        end
        do_adv(b);
        chk("R8 advance after last", int'(beat_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R11 watchdog expired: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 valid at reset", int'(beat_valid), 0);
        chk("R1 err at reset", int'(mode_err), 0);
        chk("R1 col at reset", int'(beat_col), 0);
        rst_n = 1'b1;
        do_adv(0);
        chk("R8 advance on idle bank", int'(beat_valid), 0);
        // R1 default mode: length 2 sequential
        do_start(0, 10'h005);
        chk("R1 default start", int'(beat_col), 'h005);
        do_adv(0);
        chk("R1 default seq col", int'(beat_col), 'h004);
        chk("R1 default last", int'(beat_last), 1);

        // vector table walk
        for (int i = 0; i < 12; i++) begin
            run_burst(int'(VEC[i][11:10]), VEC[i][9:0], int'(VEC[i][13:12]),
                      VEC[i][14], 1'b0);
        end

        // every bank, start offset, length and ordering (R2 R5 R6)
        for (int lg = 1; lg <= 3; lg++)
            for (int it = 0; it < 2; it++)
                for (int s = 0; s < 8; s++)
                    for (int b = 0; b < 4; b++)
                        run_burst(b, COL_W'(10'h2d0 | s | (b << 3)), lg, it[0], 1'b1);

        // R9 interleaved banks and mode change during a burst
        do_mrs(3'd3, 1'b1);
        do_start(0, 10'h0a3);
        do_mrs(3'd1, 1'b0);
        do_start(1, 10'h151);
        do_adv(0);
        chk("R9 bank0 beat1", int'(beat_col), int'(exp_col(10'h0a3, 3, 1'b1, 1)));
        do_adv(1);
        chk("R9 bank1 beat1", int'(beat_col), int'(exp_col(10'h151, 1, 1'b0, 1)));
        chk("R9 bank1 last", int'(beat_last), 1);
        for (int n = 2; n < 8; n++) begin
            do_adv(0);
            chk("R9 bank0 keeps mode", int'(beat_col), int'(exp_col(10'h0a3, 3, 1'b1, n)));
        end
        chk("R9 bank0 last", int'(beat_last), 1);

        // R10 start and advance on same bank
        do_mrs(3'd3, 1'b0);
        do_start(1, 10'h008);
        do_adv(1);
        do_adv(1);
        chk("R10 pre col", int'(beat_col), 'h00a);
        start_valid = 1'b1; start_bank = 2'd1; start_col = 10'h020;
        adv_valid = 1'b1; adv_bank = 2'd1;
        tick();
        chk("R10 same bank restart", int'(beat_col), 'h020);
        do_adv(1);
        chk("R10 count from zero", int'(beat_col), 'h021);
        // R10 start and advance on different banks
        do_start(2, 10'h040);
        do_adv(2);
        start_valid = 1'b1; start_bank = 2'd3; start_col = 10'h013;
        adv_valid = 1'b1; adv_bank = 2'd2;
        tick();
        chk("R10 start shown", int'(beat_col), 'h013);
        do_adv(2);
        chk("R10 other advance dropped", int'(beat_col), 'h042);

        // R11 idle cycle
        tick();
        chk("R11 idle no beat", int'(beat_valid), 0);

        // R3 reserved codes
        do_mrs(3'd2, 1'b1);
        do_mrs(3'd0, 1'b0);
        chk("R3 err set", int'(mode_err), 1);
        do_mrs(3'd7, 1'b0);
        chk("R3 err stays", int'(mode_err), 1);
        do_start(0, 10'h1f1);
        do_adv(0);
        chk("R3 mode kept col", int'(beat_col), int'(exp_col(10'h1f1, 2, 1'b1, 1)));
        do_adv(0);
        do_adv(0);
        chk("R3 mode kept last", int'(beat_last), 1);
        do_mrs(3'd1, 1'b0);
        chk("R3 err cleared", int'(mode_err), 0);

        // R1 reset in mid burst
        do_mrs(3'd3, 1'b0);
        do_start(2, 10'h100);
        do_mrs(3'd0, 1'b0);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        chk("R1 err after reset", int'(mode_err), 0);
        do_adv(2);
        chk("R1 bank idle after reset", int'(beat_valid), 0);
        do_start(2, 10'h103);
        do_adv(2);
        chk("R1 length 2 after reset", int'(beat_col), 'h102);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule